// File: doc/BRIEF.md
# L1 Cache Maintenance Command Unit

This block is the maintenance side of a small direct-mapped data cache and a virtually indexed instruction cache. Software drives it with register writes on a simple write port. A write either sets up state or starts an operation. The state is the invalidate-mode bit and the physical tag halves. The operations are whole-cache invalidate or flush, per-line data invalidate or flush, and instruction-cache line or whole invalidate. Dirty data lines that must be written back are presented, one at a time, on a valid/ready request port toward memory.

A single state machine sequences every operation and has four states. `ST_IDLE` accepts commands and array fills. `ST_LINE` looks up the one addressed set for a per-line command. `ST_WALK` steps a set counter across the whole array. `ST_WB` holds a write-back request until memory accepts it. The transitions are as follows. Idle goes to line on a per-line command, and to walk on a whole-cache command whose data bit 0 is 1. Line goes to write-back on a dirty hit that needs write-back, and otherwise back to idle. Walk goes to write-back on a dirty valid set that needs write-back; it goes to idle after the last set, and otherwise it advances the counter. Write-back, once accepted, goes back to walk if sets remain, and otherwise to idle.

While the machine is busy, any write, and any read of the instruction-cache control register, is held off by `hold` and is not dropped. The tag arrays are filled through a fill port, which acts only in idle. They are observed through a combinational probe port. Both ports stand in for the normal access path.

Top module: `l1_maint_unit`

## Requirements
- R1: After reset every data and instruction line is invalid, register 0 (control) reads 0, `wb_valid` is 0 and `hold` is 0.
- R2: With control bit 0 (invalidate mode) clear, a write to register 3 (data line invalidate) invalidates a matching line without any write-back, even when the line is dirty.
- R3: With control bit 0 set, a data line invalidate on a dirty matching line first writes back that line at address {tag, zero offset}, then invalidates it.
- R4: A write to register 4 (data line flush) writes back a dirty matching line and leaves it valid and clean; a clean line causes no write-back.
- R5: A line command whose tag does not match returns to idle one cycle after acceptance, with no write-back, and control bit 1 stays 0.
- R6: Writing 1 to register 2 (flush all) writes back each dirty line exactly once and leaves all lines valid and clean.
- R7: Writing 1 to register 1 (invalidate all) clears every data line; with control bit 0 set, the dirty lines are written back first.
- R8: The whole-cache registers 1, 2 and 7 start nothing when bit 0 of the written data is 0.
- R9: Control bit 1 (flush busy) reads 1 while a write-back is outstanding and 0 once the operation ends.
- R10: A write to register 5 (tag low) latches the physical tag {register 6 (tag high, 8 bits), data}. A later write to register 6 does not change the latched tag.
- R11: In tag-register mode, the set index of a line command comes from data bits [OFS+IDX-1:OFS], and byte-offset bits are ignored.
- R12: In stuffed-index mode, the index is {data bits of the stuffed field, data[PAGE_SHIFT-1:OFS]}, where data[4:0] carries the virtual bits above the page; the tag is {tag high, data} without offset.
- R13: Register 8 (instruction line invalidate) clears a matching instruction line only, leaving data lines untouched. Writing 1 to register 7 clears all instruction lines, and a read of register 9 is held off until that walk finishes.
- R14: A write that arrives while an operation is busy is held by `hold`, has no effect while held, and takes effect after the operation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 4 | Register number of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 4 | Register number of the read |
| rd_data | output | 32 | Read data (combinational) |
| hold | output | 1 | Request held off; retry next cycle |
| wb_valid | output | 1 | Write-back request |
| wb_addr | output | PA_W | Line-aligned physical address of the write-back |
| wb_ready | input | 1 | Memory accepts the write-back |
| fill_en | input | 1 | Install a line (idle only) |
| fill_icache | input | 1 | Fill targets the instruction array |
| fill_idx | input | log2(SETS) | Set to fill |
| fill_tag | input | PA_W-OFS | Physical line number to install |
| fill_dirty | input | 1 | Installed data line is dirty |
| probe_idx | input | log2(SETS) | Set to observe |
| probe_tag | input | PA_W-OFS | Line number to compare |
| probe_dc_hit | output | 1 | Data line valid and matching |
| probe_dc_dirty | output | 1 | Data line dirty bit |
| probe_ic_hit | output | 1 | Instruction line valid and matching |

## Verification
The bench builds two instances. The first uses the defaults: 40-bit physical addresses, 32-byte lines, 16 sets, an 8 KiB page and tag-register mode. This instance reaches every per-line mode and tag combination. It also reaches full-array walks and the stalled write-back window, during which busy status and held commands can be observed. The second instance uses stuffed-index mode with a 128-byte page. This makes the index wider than the in-page bits, so the stuffed virtual bits must select the set. Sixteen sets keep each walk short enough for the instruction-control read stall to be seen and timed.

// File: rtl/l1m_pkg.sv
package l1m_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LINE,
        ST_WALK,
        ST_WB
    } l1m_state_e;

    typedef struct packed {
        logic icache;
        logic inv;
        logic wback;
        logic walk;
    } l1m_op_t;

    localparam logic [3:0] RA_CTRL       = 4'd0;
    localparam logic [3:0] RA_DINV_ALL   = 4'd1;
    localparam logic [3:0] RA_DFLUSH_ALL = 4'd2;
    localparam logic [3:0] RA_DINV_LINE  = 4'd3;
    localparam logic [3:0] RA_DFLSH_LINE = 4'd4;
    localparam logic [3:0] RA_TAG_LO     = 4'd5;
    localparam logic [3:0] RA_TAG_HI     = 4'd6;
    localparam logic [3:0] RA_IINV_ALL   = 4'd7;
    localparam logic [3:0] RA_IINV_LINE  = 4'd8;
    localparam logic [3:0] RA_ICTRL      = 4'd9;

endpackage

// File: rtl/l1m_tag_store.sv
module l1m_tag_store #(
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 35,
    parameter int HAS_DIRTY = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output logic             a_valid,
    output logic [TAG_W-1:0] a_tag,
    output logic             a_dirty,
    input  logic [IDX_W-1:0] b_idx,
    output logic             b_valid,
    output logic [TAG_W-1:0] b_tag,
    output logic             b_dirty,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic             w_valid,
    input  logic             w_dirty,
    input  logic [TAG_W-1:0] w_tag
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_mem [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else if (we)
            vld_q[w_idx] <= w_valid;
    end

    always_ff @(posedge clk) begin
        if (we)
            tag_mem[w_idx] <= w_tag;
    end

    assign a_valid = vld_q[a_idx];
    assign a_tag   = tag_mem[a_idx];
    assign b_valid = vld_q[b_idx];
    assign b_tag   = tag_mem[b_idx];

    generate
        if (HAS_DIRTY != 0) begin : g_dirty
            logic [SETS-1:0] dty_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dty_q <= '0;
                else if (we)
                    dty_q[w_idx] <= w_dirty;
            end
            assign a_dirty = dty_q[a_idx];
            assign b_dirty = dty_q[b_idx];
        end else begin : g_clean
            logic unused_dirty;
            assign unused_dirty = w_dirty;
            assign a_dirty = 1'b0;
            assign b_dirty = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/l1m_line_decode.sv
module l1m_line_decode #(
    parameter int PA_W          = 40,
    parameter int OFS_W         = 5,
    parameter int IDX_W         = 4,
    parameter int PAGE_SHIFT    = 13,
    parameter int STUFFED_INDEX = 0
) (
    input  logic [31:0]           cmd_data,
    input  logic [PA_W-1:0]       ptag,
    input  logic [PA_W-33:0]      hi,
    output logic [IDX_W-1:0]      idx,
    output logic [PA_W-OFS_W-1:0] tag
);
    localparam int PB = PAGE_SHIFT - OFS_W;

    generate
        if (STUFFED_INDEX == 0) begin : g_ptag
            assign idx = cmd_data[OFS_W+IDX_W-1:OFS_W];
            assign tag = ptag[PA_W-1:OFS_W];
        end else begin : g_stuffed
            logic [PA_W-1:0] pa;
            assign pa  = {hi, cmd_data};
            assign tag = pa[PA_W-1:OFS_W];
            if (PB >= IDX_W) begin : g_inpage
                assign idx = cmd_data[OFS_W+IDX_W-1:OFS_W];
            end else begin : g_alias
                assign idx = {cmd_data[IDX_W-PB-1:0], cmd_data[PAGE_SHIFT-1:OFS_W]};
            end
        end
    endgenerate

endmodule

// File: rtl/l1_maint_unit.sv
module l1_maint_unit
    import l1m_pkg::*;
#(
    parameter int PA_W          = 40,
    parameter int LINE_BYTES    = 32,
    parameter int SETS          = 16,
    parameter int PAGE_SHIFT    = 13,
    parameter int STUFFED_INDEX = 0
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [3:0]                            wr_addr,
    input  logic [31:0]                           wr_data,
    input  logic                                  rd_en,
    input  logic [3:0]                            rd_addr,
    output logic [31:0]                           rd_data,
    output logic                                  hold,
    output logic                                  wb_valid,
    output logic [PA_W-1:0]                       wb_addr,
    input  logic                                  wb_ready,
    input  logic                                  fill_en,
    input  logic                                  fill_icache,
    input  logic [$clog2(SETS)-1:0]               fill_idx,
    input  logic [PA_W-$clog2(LINE_BYTES)-1:0]    fill_tag,
    input  logic                                  fill_dirty,
    input  logic [$clog2(SETS)-1:0]               probe_idx,
    input  logic [PA_W-$clog2(LINE_BYTES)-1:0]    probe_tag,
    output logic                                  probe_dc_hit,
    output logic                                  probe_dc_dirty,
    output logic                                  probe_ic_hit
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = PA_W - OFS_W;
    localparam int HI_W  = PA_W - 32;

    l1m_state_e       state_q, state_d;
    l1m_op_t          op_q, op_d;
    logic [IDX_W-1:0] cnt_q, cnt_d, idx_q, idx_d;
    logic [TAG_W-1:0] tag_q, tag_d;
    logic             inv_mode_q;
    logic [HI_W-1:0]  hi_q;
    logic [PA_W-1:0]  ptag_q;

    logic             acc, trig, last, need_wb, line_hit, flush_busy;
    logic [IDX_W-1:0] cur_idx, dec_idx;
    logic [TAG_W-1:0] dec_tag;

    logic             dc_v, dc_d, ic_v, ic_d;
    logic [TAG_W-1:0] dc_t, ic_t;
    logic             pdc_v, pic_v, pic_d;
    logic [TAG_W-1:0] pdc_t, pic_t;
    logic             dc_we, dc_wv, dc_wd, ic_we, ic_wv;
    logic [IDX_W-1:0] dc_wi, ic_wi;
    logic [TAG_W-1:0] dc_wt, ic_wt;

    l1m_line_decode #(
        .PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(IDX_W),
        .PAGE_SHIFT(PAGE_SHIFT), .STUFFED_INDEX(STUFFED_INDEX)
    ) u_dec (
        .cmd_data(wr_data), .ptag(ptag_q), .hi(hi_q),
        .idx(dec_idx), .tag(dec_tag)
    );

    l1m_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HAS_DIRTY(1)) u_dstore (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cur_idx), .a_valid(dc_v), .a_tag(dc_t), .a_dirty(dc_d),
        .b_idx(probe_idx), .b_valid(pdc_v), .b_tag(pdc_t), .b_dirty(probe_dc_dirty),
        .we(dc_we), .w_idx(dc_wi), .w_valid(dc_wv), .w_dirty(dc_wd), .w_tag(dc_wt)
    );

    l1m_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HAS_DIRTY(0)) u_istore (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cur_idx), .a_valid(ic_v), .a_tag(ic_t), .a_dirty(ic_d),
        .b_idx(probe_idx), .b_valid(pic_v), .b_tag(pic_t), .b_dirty(pic_d),
        .we(ic_we), .w_idx(ic_wi), .w_valid(ic_wv), .w_dirty(1'b0), .w_tag(ic_wt)
    );

    assign acc      = wr_en && (state_q == ST_IDLE);
    assign trig     = wr_data[0];
    assign cur_idx  = op_q.walk ? cnt_q : idx_q;
    assign last     = (cnt_q == {IDX_W{1'b1}});
    assign line_hit = op_q.icache ? (ic_v && ic_t == tag_q) : (dc_v && dc_t == tag_q);
    assign need_wb  = op_q.wback && !op_q.icache && dc_v && dc_d;

    // State register and software-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= '0;
            cnt_q      <= '0;
            idx_q      <= '0;
            tag_q      <= '0;
            inv_mode_q <= 1'b0;
            hi_q       <= '0;
            ptag_q     <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            tag_q   <= tag_d;
            if (acc && wr_addr == RA_CTRL)   inv_mode_q <= wr_data[0];
            if (acc && wr_addr == RA_TAG_HI) hi_q       <= wr_data[HI_W-1:0];
            if (acc && wr_addr == RA_TAG_LO) ptag_q     <= {hi_q, wr_data};
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        tag_d   = tag_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc) begin
                    idx_d = dec_idx;
                    tag_d = dec_tag;
                    cnt_d = '0;
                    case (wr_addr)
                        RA_DINV_ALL: if (trig) begin
                            op_d = '{icache: 1'b0, inv: 1'b1, wback: inv_mode_q, walk: 1'b1};
                            state_d = ST_WALK;
                        end
                        RA_DFLUSH_ALL: if (trig) begin
                            op_d = '{icache: 1'b0, inv: 1'b0, wback: 1'b1, walk: 1'b1};
                            state_d = ST_WALK;
                        end
                        RA_IINV_ALL: if (trig) begin
                            op_d = '{icache: 1'b1, inv: 1'b1, wback: 1'b0, walk: 1'b1};
                            state_d = ST_WALK;
                        end
                        RA_DINV_LINE: begin
                            op_d = '{icache: 1'b0, inv: 1'b1, wback: inv_mode_q, walk: 1'b0};
                            state_d = ST_LINE;
                        end
                        RA_DFLSH_LINE: begin
                            op_d = '{icache: 1'b0, inv: 1'b0, wback: 1'b1, walk: 1'b0};
                            state_d = ST_LINE;
                        end
                        RA_IINV_LINE: begin
                            op_d = '{icache: 1'b1, inv: 1'b1, wback: 1'b0, walk: 1'b0};
                            state_d = ST_LINE;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_LINE: state_d = (line_hit && need_wb) ? ST_WB : ST_IDLE;
            ST_WALK: begin
                if (need_wb)
                    state_d = ST_WB;
                else if (last)
                    state_d = ST_IDLE;
                else
                    cnt_d = cnt_q + 1'b1;
            end
            ST_WB: begin
                if (wb_ready) begin
                    if (op_q.walk && !last) begin
                        cnt_d   = cnt_q + 1'b1;
                        state_d = ST_WALK;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and array updates
    always_comb begin
        dc_we = 1'b0;  dc_wi = fill_idx; dc_wv = 1'b1; dc_wd = fill_dirty; dc_wt = fill_tag;
        ic_we = 1'b0;  ic_wi = fill_idx; ic_wv = 1'b1; ic_wt = fill_tag;
        wb_valid   = 1'b0;
        flush_busy = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                dc_we = fill_en && !fill_icache;
                ic_we = fill_en && fill_icache;
            end
            ST_LINE: begin
                if (op_q.icache) begin
                    ic_we = line_hit; ic_wi = idx_q; ic_wv = 1'b0; ic_wt = ic_t;
                end else begin
                    dc_we = line_hit && !need_wb && op_q.inv;
                    dc_wi = idx_q; dc_wv = 1'b0; dc_wd = 1'b0; dc_wt = dc_t;
                end
            end
            ST_WALK: begin
                flush_busy = op_q.wback;
                if (op_q.icache) begin
                    ic_we = 1'b1; ic_wi = cnt_q; ic_wv = 1'b0; ic_wt = ic_t;
                end else begin
                    dc_we = !need_wb && op_q.inv;
                    dc_wi = cnt_q; dc_wv = 1'b0; dc_wd = 1'b0; dc_wt = dc_t;
                end
            end
            ST_WB: begin
                wb_valid   = 1'b1;
                flush_busy = 1'b1;
                dc_we = wb_ready; dc_wi = cur_idx; dc_wv = !op_q.inv; dc_wd = 1'b0; dc_wt = dc_t;
            end
            default: ;
        endcase
    end

    assign wb_addr        = {dc_t, {OFS_W{1'b0}}};
    assign hold           = (state_q != ST_IDLE) && (wr_en || (rd_en && rd_addr == RA_ICTRL));
    assign probe_dc_hit   = pdc_v && (pdc_t == probe_tag);
    assign probe_ic_hit   = pic_v && (pic_t == probe_tag) && !pic_d;

    always_comb begin
        case (rd_addr)
            RA_CTRL:   rd_data = {30'd0, flush_busy, inv_mode_q};
            RA_TAG_HI: rd_data = {{(32-HI_W){1'b0}}, hi_q};
            RA_TAG_LO: rd_data = ptag_q[31:0];
            default:   rd_data = {31'd0, ic_d};
        endcase
    end

endmodule

// File: rtl/l1m_checker.sv
module l1m_checker
    import l1m_pkg::*;
#(
    parameter int PA_W = 40,
    parameter int HI_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic             hold,
    input logic             wb_valid,
    input logic             wb_ready,
    input logic [PA_W-1:0]  wb_addr,
    input l1m_state_e       state_q,
    input logic             line_hit,
    input logic             inv_mode_q,
    input logic [HI_W-1:0]  hi_q,
    input logic [PA_W-1:0]  ptag_q
);

    // R6
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

    // R5
    miss_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LINE) && !line_hit |=> (state_q == ST_IDLE) && !wb_valid);

    // R10
    ptag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !hold && (wr_addr == RA_TAG_LO) |=> ptag_q == {$past(hi_q), $past(wr_data)});

    // R3
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !hold && (wr_addr == RA_CTRL) |=> inv_mode_q == $past(wr_data[0]));

    // R14
    held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && hold |=> $stable(inv_mode_q) && $stable(hi_q) && $stable(ptag_q));

endmodule

bind l1_maint_unit l1m_checker #(.PA_W(PA_W), .HI_W(HI_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hold(hold), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .state_q(state_q), .line_hit(line_hit), .inv_mode_q(inv_mode_q),
    .hi_q(hi_q), .ptag_q(ptag_q)
);

// File: tb/tb_l1_maint_unit.sv
module tb_l1_maint_unit;

    localparam logic [3:0] A_CTRL = 4'd0, A_DINV_ALL = 4'd1, A_DFL_ALL = 4'd2,
                           A_DINV_LN = 4'd3, A_DFL_LN = 4'd4, A_TLO = 4'd5,
                           A_THI = 4'd6, A_IINV_ALL = 4'd7, A_IINV_LN = 4'd8,
                           A_ICTRL = 4'd9;

    // dirty, mode, flush, match, exp_wb[1:0], exp_hit, exp_dirty
    localparam logic [7:0] VEC [7] = '{8'h90, 8'hD4, 8'hB6, 8'h72, 8'hC3, 8'h10, 8'hE3};

    localparam logic [39:0] PA_A = 40'h3C_8765_4320;
    localparam logic [39:0] PA_B = 40'h3C_8765_4720;
    localparam logic [34:0] T_A  = PA_A[39:5];
    localparam logic [34:0] T_B  = PA_B[39:5];
    localparam logic [39:0] PA_L = 40'h3C_1234_5640;
    localparam logic [34:0] T_L  = PA_L[39:5];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        wr_en = 0, rd_en = 0, wb_ready = 1, fill_en = 0, fill_icache = 0, fill_dirty = 0;
    logic [3:0]  wr_addr = 0, rd_addr = 0, fill_idx = 0, probe_idx = 0;
    logic [31:0] wr_data = 0;
    logic [34:0] fill_tag = 0, probe_tag = 0;
    logic [31:0] rd_data;
    logic        hold, wb_valid, probe_dc_hit, probe_dc_dirty, probe_ic_hit;
    logic [39:0] wb_addr;

    logic        wr_en_l = 0, fill_en_l = 0, fill_dirty_l = 0;
    logic [3:0]  wr_addr_l = 0, fill_idx_l = 0, probe_idx_l = 0;
    logic [31:0] wr_data_l = 0;
    logic [34:0] fill_tag_l = 0, probe_tag_l = 0;
    logic [31:0] rd_data_l;
    logic        hold_l, wb_valid_l, hit_l, dirty_l, ihit_l;
    logic [39:0] wb_addr_l;

    int checks = 0, errors = 0, wb_cnt = 0, wb_cnt_l = 0;
    logic [39:0] wb_last = 0, wb_last_l = 0;

    l1_maint_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .hold(hold),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
        .fill_en(fill_en), .fill_icache(fill_icache), .fill_idx(fill_idx),
        .fill_tag(fill_tag), .fill_dirty(fill_dirty), .probe_idx(probe_idx),
        .probe_tag(probe_tag), .probe_dc_hit(probe_dc_hit),
        .probe_dc_dirty(probe_dc_dirty), .probe_ic_hit(probe_ic_hit)
    );

    l1_maint_unit #(.PAGE_SHIFT(7), .STUFFED_INDEX(1)) dut_leg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_l), .wr_addr(wr_addr_l), .wr_data(wr_data_l),
        .rd_en(1'b0), .rd_addr(4'd0), .rd_data(rd_data_l), .hold(hold_l),
        .wb_valid(wb_valid_l), .wb_addr(wb_addr_l), .wb_ready(1'b1),
        .fill_en(fill_en_l), .fill_icache(1'b0), .fill_idx(fill_idx_l),
        .fill_tag(fill_tag_l), .fill_dirty(fill_dirty_l), .probe_idx(probe_idx_l),
        .probe_tag(probe_tag_l), .probe_dc_hit(hit_l),
        .probe_dc_dirty(dirty_l), .probe_ic_hit(ihit_l)
    );

    always @(posedge clk) begin
        if (wb_valid && wb_ready) begin wb_cnt <= wb_cnt + 1; wb_last <= wb_addr; end
        if (wb_valid_l) begin wb_cnt_l <= wb_cnt_l + 1; wb_last_l <= wb_addr_l; end
    end

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        #1;
        while (hold) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        rd_en = 1; rd_addr = A_ICTRL;
        #1;
        while (hold) begin @(negedge clk); #1; end
        rd_en = 0;
    endtask

    task automatic fill(input logic ic, input logic [3:0] idx, input logic [34:0] t, input logic d);
        @(negedge clk);
        fill_en = 1; fill_icache = ic; fill_idx = idx; fill_tag = t; fill_dirty = d;
        @(posedge clk); #1;
        fill_en = 0;
    endtask

    task automatic probe(input string r, input logic [3:0] idx, input logic [34:0] t,
                         input logic eh, input logic ed);
        @(negedge clk);
        probe_idx = idx; probe_tag = t;
        #1;
        chk(r, probe_dc_hit, eh);
        if (eh) chk(r, probe_dc_dirty, ed);
    endtask

    task automatic rd_ctrl(output logic [31:0] d);
        @(negedge clk);
        rd_addr = A_CTRL;
        #1;
        d = rd_data;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd_ctrl(d);
        chk("R1 ctrl", d, 0);
        chk("R1 wb_valid", wb_valid, 0);
        wait_idle();
        chk("R1 hold", hold, 0);
        probe("R1 empty", 4'd3, T_A, 1'b0, 1'b0);

        // table: R2 R3 R4 R11 (offset bits 0x1B in the command are ignored)
        for (int i = 0; i < 7; i++) begin
            logic [7:0] v;
            v = VEC[i];
            fill(1'b0, 4'd3, T_A, v[7]);
            reg_wr(A_CTRL, {31'd0, v[6]});
            reg_wr(A_THI, 32'h3C);
            reg_wr(A_TLO, v[4] ? PA_A[31:0] : PA_B[31:0]);
            w0 = wb_cnt;
            reg_wr(v[5] ? A_DFL_LN : A_DINV_LN, 32'h7000_007B);
            wait_idle();
            chk($sformatf("R2 R3 R4 R11 vec%0d wb count", i), wb_cnt - w0, v[3:2]);
            if (v[3:2] != 0) chk($sformatf("R3 R4 vec%0d wb addr", i), wb_last, PA_A);
            probe($sformatf("R2 R3 R4 vec%0d line state", i), 4'd3, T_A, v[1], v[0]);
        end

        // R5 miss timing
        reg_wr(A_CTRL, 32'd1);
        fill(1'b0, 4'd4, T_A, 1'b1);
        reg_wr(A_TLO, PA_B[31:0]);
        w0 = wb_cnt;
        @(negedge clk);
        wr_en = 1; wr_addr = A_DFL_LN; wr_data = 32'h0000_0080;
        @(posedge clk); #1;
        wr_en = 0;
        rd_addr = A_CTRL; #1;
        chk("R5 status during lookup", rd_data[1], 0);
        @(posedge clk); #1;
        rd_en = 1; rd_addr = A_ICTRL; #1;
        chk("R5 idle after one cycle", hold, 0);
        rd_en = 0;
        chk("R5 no write-back", wb_cnt - w0, 0);
        probe("R5 line untouched", 4'd4, T_A, 1'b1, 1'b1);

        // R9 R14 stalled write-back and held command
        reg_wr(A_CTRL, 32'd0);
        reg_wr(A_TLO, PA_A[31:0]);
        fill(1'b0, 4'd6, T_A, 1'b1);
        wb_ready = 0;
        w0 = wb_cnt;
        reg_wr(A_DFL_LN, 32'h0000_00C0);
        repeat (3) @(negedge clk);
        rd_ctrl(d);
        chk("R9 status busy", d[1], 1);
        chk("R9 wb request", wb_valid, 1);
        chk("R9 wb addr", wb_addr, PA_A);
        fork
            reg_wr(A_DINV_LN, 32'h0000_00C0);
            begin
                @(negedge clk); @(negedge clk); #2;
                chk("R14 held", hold, 1);
                @(negedge clk); @(negedge clk);
                wb_ready = 1;
            end
        join
        wait_idle();
        rd_ctrl(d);
        chk("R9 status clear", d[1], 0);
        chk("R9 one write-back", wb_cnt - w0, 1);
        probe("R14 held invalidate executed", 4'd6, T_A, 1'b0, 1'b0);

        // R7 invalidate all, mode clear
        reg_wr(A_DINV_ALL, 32'd1);
        wait_idle();
        probe("R7 cleared", 4'd4, T_A, 1'b0, 1'b0);

        // R6 flush all
        fill(1'b0, 4'd0, T_A, 1'b1);
        fill(1'b0, 4'd5, T_B, 1'b1);
        fill(1'b0, 4'd15, T_A, 1'b1);
        fill(1'b0, 4'd7, T_B, 1'b0);
        w0 = wb_cnt;
        reg_wr(A_DFL_ALL, 32'd1);
        wait_idle();
        chk("R6 wb count", wb_cnt - w0, 3);
        probe("R6 kept clean", 4'd5, T_B, 1'b1, 1'b0);
        probe("R6 clean kept", 4'd7, T_B, 1'b1, 1'b0);

        // R8 bit 0 clear does nothing
        fill(1'b0, 4'd5, T_B, 1'b1);
        w0 = wb_cnt;
        reg_wr(A_DFL_ALL, 32'd0);
        reg_wr(A_DINV_ALL, 32'd2);
        reg_wr(A_IINV_ALL, 32'd0);
        wait_idle();
        chk("R8 no wb", wb_cnt - w0, 0);
        probe("R8 line kept", 4'd5, T_B, 1'b1, 1'b1);

        // R7 invalidate all with mode set
        reg_wr(A_CTRL, 32'd1);
        fill(1'b0, 4'd0, T_A, 1'b1);
        w0 = wb_cnt;
        reg_wr(A_DINV_ALL, 32'd1);
        wait_idle();
        chk("R7 wb count", wb_cnt - w0, 2);
        probe("R7 dirty gone", 4'd5, T_B, 1'b0, 1'b0);
        probe("R7 clean gone", 4'd7, T_B, 1'b0, 1'b0);

        // R10 tag latch ordering
        fill(1'b0, 4'd3, T_A, 1'b1);
        reg_wr(A_THI, 32'h3C);
        reg_wr(A_TLO, PA_A[31:0]);
        reg_wr(A_THI, 32'h11);
        w0 = wb_cnt;
        reg_wr(A_DFL_LN, 32'h0000_0060);
        wait_idle();
        chk("R10 latched tag used", wb_cnt - w0, 1);
        probe("R10 cleaned", 4'd3, T_A, 1'b1, 1'b0);

        // R13 instruction cache
        fill(1'b0, 4'd2, T_A, 1'b1);
        fill(1'b1, 4'd2, T_A, 1'b0);
        reg_wr(A_THI, 32'h3C);
        reg_wr(A_TLO, PA_B[31:0]);
        reg_wr(A_IINV_LN, 32'h0000_0040);
        wait_idle();
        @(negedge clk); probe_idx = 4'd2; probe_tag = T_A; #1;
        chk("R13 ic mismatch kept", probe_ic_hit, 1);
        reg_wr(A_TLO, PA_A[31:0]);
        reg_wr(A_IINV_LN, 32'h0000_0040);
        wait_idle();
        @(negedge clk); probe_idx = 4'd2; probe_tag = T_A; #1;
        chk("R13 ic line cleared", probe_ic_hit, 0);
        chk("R13 dc untouched", probe_dc_dirty, 1);
        fill(1'b1, 4'd1, T_A, 1'b0);
        fill(1'b1, 4'd10, T_B, 1'b0);
        reg_wr(A_IINV_ALL, 32'd1);
        @(negedge clk); rd_en = 1; rd_addr = A_ICTRL; #1;
        chk("R13 ictrl read held", hold, 1);
        rd_en = 0;
        wait_idle();
        @(negedge clk); probe_idx = 4'd10; probe_tag = T_B; #1;
        chk("R13 ic all cleared", probe_ic_hit, 0);

        // R12 stuffed-index instance: index {2'b11, 2'b10} = 14
        @(negedge clk);
        fill_en_l = 1; fill_idx_l = 4'd14; fill_tag_l = T_L; fill_dirty_l = 1;
        @(negedge clk);
        fill_idx_l = 4'd2;
        @(negedge clk);
        fill_en_l = 0;
        wr_en_l = 1; wr_addr_l = A_THI; wr_data_l = 32'h3C;
        @(negedge clk);
        wr_addr_l = A_DFL_LN; wr_data_l = 32'h1234_5643;
        @(negedge clk);
        wr_en_l = 0;
        repeat (5) @(negedge clk);
        chk("R12 one wb", wb_cnt_l, 1);
        chk("R12 wb addr", wb_last_l, PA_L);
        probe_idx_l = 4'd14; probe_tag_l = T_L; #1;
        chk("R12 stuffed set cleaned", dirty_l, 0);
        probe_idx_l = 4'd2; #1;
        chk("R12 other set dirty", dirty_l, 1);

        summary();
        $finish;
    end

endmodule